// File: doc/BRIEF.md
# Board Identification Shift Register

This block lives in the small programmable-logic device of an add-on card. It lets a host with only a handful of general-purpose pins find out how many card slots the board has. The host holds the card reset line active. While it does, the block borrows three host lines. The two card-enable lines choose what the block does on each tick:

- enable 1 high with enable 2 low selects load;
- enable 1 low with enable 2 high selects read;
- both high or both low hold the register.

The write-strobe line is the tick. One rising edge in load mode captures a fixed identity code. Each rising edge in read mode moves that code one bit toward the output. The current output bit is driven on the slot-0 card-detect line.

The default identity code is 8'hC2, which means a dual-slot board. A host that collects any other value assumes a single slot. The code leaves least significant bit first. Bit 0 is therefore on the line as soon as the load tick has been taken, before any read tick. Zeros fill in from the top, so ticks past the code width read 0.

All host lines are brought into the block's own clock domain through a synchronizer before use. When the card reset line is not held, the card-detect output carries the real slot-0 presence signal straight through. In that state the identity register is kept cleared.

Top module: `board_id_shifter`

## Requirements
- R1: While the synchronized card reset is low, `card_det_o` equals `card_det_i` in the same cycle, whatever the enables and strobe do.
- R2: While the synchronized card reset is high, `card_det_o` shows the current identity output bit and does not follow `card_det_i`.
- R3: A rising edge of `wr_strobe_i`, with `card_en1_i`=1 and `card_en2_i`=0 while reset is held, loads `ID_CODE`. After it, `card_det_o` shows `ID_CODE` bit 0 (0 for 8'hC2).
- R4: Each rising strobe edge with `card_en1_i`=0 and `card_en2_i`=1 while reset is held shifts the register one place toward bit 0. Eight such edges after a load present 8'hC2 least significant bit first: 0,1,0,0,0,0,1,1.
- R5: Zeros enter at the top during read shifts, so read edges beyond `ID_W` after a load give 0.
- R6: A strobe edge with both enables high, or both low, leaves the register and output unchanged.
- R7: While card reset is not held, strobe edges are ignored and the register is cleared. After reset is re-asserted, read edges without a new load give all zeros, and a fresh load restarts the full readout.
- R8: After `rst_n` is asserted, the register is zero and the synchronized card reset is low, so `card_det_o` passes `card_det_i` through.
- R9: Only the rising strobe edge acts; a falling edge alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low block reset |
| card_reset_i | input | 1 | Host card reset, high = held (identity function enabled) |
| card_en1_i | input | 1 | Card-enable line 1, mode select |
| card_en2_i | input | 1 | Card-enable line 2, mode select |
| wr_strobe_i | input | 1 | Write-strobe line, used as the shift tick on its rising edge |
| card_det_i | input | 1 | Real slot-0 card-detect signal |
| card_det_o | output | 1 | Slot-0 card-detect line toward the host (identity data while reset is held) |

## Verification
The bench reads the code out in full and checks the bit order. A design that shifts the wrong way, or that needs one extra tick before bit 0 shows, reads back something other than 8'hC2. It keeps ticking past eight bits to catch a register that rotates instead of filling with zeros. It ticks in both hold mode combinations to catch a decoder that treats a half-matched enable pair as read. It drives the falling edge on its own, and ticks while card reset is released, so that a design that acts on the wrong edge or forgets to gate and clear on release shows a stale bit on the card-detect line.

// File: rtl/bid_pkg.sv
package bid_pkg;

   typedef enum logic [1:0] {
      BID_MODE_HOLD = 2'd0,
      BID_MODE_LOAD = 2'd1,
      BID_MODE_READ = 2'd2
   } bid_mode_e;

   // Enable lines in opposite states pick the operation; equal states hold.
   function automatic bid_mode_e bid_decode(input logic en1, input logic en2);
      bid_mode_e m;
      unique case ({en1, en2})
         2'b10:   m = BID_MODE_LOAD;
         2'b01:   m = BID_MODE_READ;
         default: m = BID_MODE_HOLD;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/bid_sync.sv
module bid_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bid_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("bid_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign q_o = stg[LAST];

endmodule

// File: rtl/bid_ctrl.sv
module bid_ctrl
   import bid_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic held_i,
   input  logic en1_i,
   input  logic en2_i,
   input  logic strobe_i,
   output logic load_o,
   output logic shift_o,
   output logic clear_o
);
   logic      strobe_q;
   logic      strobe_rise;
   bid_mode_e mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= strobe_i;
   end

   assign strobe_rise = strobe_i & ~strobe_q;
   assign mode        = bid_decode(en1_i, en2_i);

   always_comb begin
      load_o  = 1'b0;
      shift_o = 1'b0;
      if (held_i && strobe_rise) begin
         load_o  = (mode == BID_MODE_LOAD);
         shift_o = (mode == BID_MODE_READ);
      end
   end

   assign clear_o = ~held_i;

   // R6: equal enables never produce a command
   a_r6_equal_enables_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (en1_i == en2_i) |-> (!load_o && !shift_o));

   // R7: nothing acts while card reset is released
   a_r7_gated_when_released: assert property (@(posedge clk) disable iff (!rst_n)
      !held_i |-> (!load_o && !shift_o));

   // R9: a command needs the strobe low in the previous cycle
   a_r9_rising_only: assert property (@(posedge clk) disable iff (!rst_n)
      (load_o || shift_o) |-> (strobe_i && !$past(strobe_i)));

   a_r3_single_command: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_o, shift_o, (load_o || shift_o) && clear_o}));

endmodule

// File: rtl/bid_shreg.sv
module bid_shreg #(
   parameter int              ID_W        = 8,
   parameter logic [ID_W-1:0] ID_CODE     = 8'hC2,
   parameter bit              LSB_FIRST   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic shift_i,
   input  logic clear_i,
   output logic bit_o
);
   localparam int TOP = ID_W - 1;

   generate
      if (ID_W < 2) begin : g_bad_width
         $error("bid_shreg: ID_W must be at least 2");
      end
   endgenerate

   logic [ID_W-1:0] q;
   logic [ID_W-1:0] q_shifted;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign q_shifted = {1'b0, q[TOP:1]};
         assign bit_o     = q[0];
         // R4/R5: one place toward bit 0, zero at the top
         a_r4_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
            (shift_i && !clear_i) |=> (q == {1'b0, $past(q[TOP:1])}));
      end else begin : g_msb
         assign q_shifted = {q[TOP-1:0], 1'b0};
         assign bit_o     = q[TOP];
         a_r4_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
            (shift_i && !clear_i) |=> (q == {$past(q[TOP-1:0]), 1'b0}));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (clear_i) q <= '0;
      else if (load_i)  q <= ID_CODE;
      else if (shift_i) q <= q_shifted;
   end

   // R3: a load leaves the code in place
   a_r3_load_code: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !clear_i) |=> (q == ID_CODE));

   // R6: no command, no change
   a_r6_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !shift_i && !clear_i) |=> $stable(q));

   // R7: released reset empties the register
   a_r7_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (q == '0));

endmodule

// File: rtl/board_id_shifter.sv
module board_id_shifter #(
   parameter int              ID_W        = 8,
   parameter logic [ID_W-1:0] ID_CODE     = 8'hC2,
   parameter int              SYNC_STAGES = 2,
   parameter bit              LSB_FIRST   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic card_reset_i,
   input  logic card_en1_i,
   input  logic card_en2_i,
   input  logic wr_strobe_i,
   input  logic card_det_i,
   output logic card_det_o
);
   localparam int N_SYNC = 4;

   logic [N_SYNC-1:0] raw_lines;
   logic [N_SYNC-1:0] sync_lines;
   logic held, en1_s, en2_s, strobe_s;
   logic load, shift, clear;
   logic id_bit;

   assign raw_lines = {card_reset_i, card_en1_i, card_en2_i, wr_strobe_i};

   bid_sync #(.W(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_lines),
      .q_o   (sync_lines)
   );

   assign {held, en1_s, en2_s, strobe_s} = sync_lines;

   bid_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .held_i   (held),
      .en1_i    (en1_s),
      .en2_i    (en2_s),
      .strobe_i (strobe_s),
      .load_o   (load),
      .shift_o  (shift),
      .clear_o  (clear)
   );

   bid_shreg #(.ID_W(ID_W), .ID_CODE(ID_CODE), .LSB_FIRST(LSB_FIRST)) u_shreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .shift_i (shift),
      .clear_i (clear),
      .bit_o   (id_bit)
   );

   assign card_det_o = held ? id_bit : card_det_i;

   // R2: while held, the line stays put unless a command acted last cycle
   a_r2_line_owned: assert property (@(posedge clk) disable iff (!rst_n)
      (held && $past(held) && !$past(load) && !$past(shift)) |-> $stable(card_det_o));

   // R7: the first held cycle after release shows a cleared register
   a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(held) |-> (card_det_o == 1'b0));

endmodule

// File: tb/board_id_shifter_tb.sv
module board_id_shifter_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic card_reset_i = 1'b0;
   logic card_en1_i = 1'b0;
   logic card_en2_i = 1'b0;
   logic wr_strobe_i = 1'b1;
   logic card_det_i = 1'b0;
   logic card_det_o;

   int n_checks = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   board_id_shifter u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .card_reset_i (card_reset_i),
      .card_en1_i   (card_en1_i),
      .card_en2_i   (card_en2_i),
      .wr_strobe_i  (wr_strobe_i),
      .card_det_i   (card_det_i),
      .card_det_o   (card_det_o)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic set_mode(input logic a, input logic b);
      card_en1_i = a;
      card_en2_i = b;
      wait_cyc(6);
   endtask

   task automatic tick();
      wr_strobe_i = 1'b0;
      wait_cyc(6);
      wr_strobe_i = 1'b1;
      wait_cyc(6);
   endtask

   task automatic read_bits(input int n, output logic [7:0] val);
      val = '0;
      for (int i = 0; i < n; i++) begin
         val[i] = card_det_o;
         tick();
      end
   endtask

   task automatic hold_reset(input logic v);
      card_reset_i = v;
      wait_cyc(6);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      card_det_i = 1'b1;
      wait_cyc(3);
      check("R8 passthru in reset", {7'd0, card_det_o}, 8'h01);
      rst_n = 1'b1;
      wait_cyc(3);
      card_det_i = 1'b0;
      #1;
      check("R8 passthru after reset", {7'd0, card_det_o}, 8'h00);
   endtask

   task automatic t_passthru();
      logic [7:0] v;
      hold_reset(1'b0);
      card_det_i = 1'b1; #1;
      check("R1 follow 1", {7'd0, card_det_o}, 8'h01);
      card_det_i = 1'b0; #1;
      check("R1 follow 0", {7'd0, card_det_o}, 8'h00);
      // R7: load attempt while released is ignored
      set_mode(1'b1, 1'b0);
      tick();
      card_det_i = 1'b1; #1;
      check("R1 follow during strobe", {7'd0, card_det_o}, 8'h01);
      card_det_i = 1'b0;
      hold_reset(1'b1);
      set_mode(1'b0, 1'b1);
      read_bits(8, v);
      check("R7 released load ignored", v, 8'h00);
      hold_reset(1'b0);
   endtask

   task automatic t_identify();
      logic [7:0] v;
      logic b0;
      hold_reset(1'b1);
      set_mode(1'b1, 1'b0);
      tick();
      check("R3 bit0 after load", {7'd0, card_det_o}, 8'h00);
      b0 = card_det_o;
      card_det_i = ~b0; #1;
      check("R2 not following card_det_i", {7'd0, card_det_o}, {7'd0, b0});
      card_det_i = 1'b0;
      set_mode(1'b0, 1'b1);
      read_bits(8, v);
      check("R4 identity readout", v, 8'hC2);
      read_bits(4, v);
      check("R5 overrun zeros", v, 8'h00);
   endtask

   task automatic t_hold();
      set_mode(1'b1, 1'b0);
      tick();
      set_mode(1'b0, 1'b1);
      tick();
      check("R4 first shift gives 1", {7'd0, card_det_o}, 8'h01);
      set_mode(1'b1, 1'b1);
      tick();
      check("R6 both high hold", {7'd0, card_det_o}, 8'h01);
      set_mode(1'b0, 1'b0);
      tick();
      check("R6 both low hold", {7'd0, card_det_o}, 8'h01);
      set_mode(1'b0, 1'b1);
      wr_strobe_i = 1'b0;
      wait_cyc(6);
      check("R9 falling edge no shift", {7'd0, card_det_o}, 8'h01);
      wr_strobe_i = 1'b1;
      wait_cyc(6);
      check("R9 rising edge shifts", {7'd0, card_det_o}, 8'h00);
   endtask

   task automatic t_restart();
      logic [7:0] v;
      set_mode(1'b1, 1'b0);
      tick();
      set_mode(1'b0, 1'b1);
      read_bits(3, v);
      check("R4 partial read", v, 8'h02);
      hold_reset(1'b0);
      card_det_i = 1'b1; #1;
      check("R1 passthru after release", {7'd0, card_det_o}, 8'h01);
      card_det_i = 1'b0;
      hold_reset(1'b1);
      read_bits(8, v);
      check("R7 cleared after release", v, 8'h00);
      set_mode(1'b1, 1'b0);
      tick();
      set_mode(1'b0, 1'b1);
      read_bits(8, v);
      check("R7 reload restarts readout", v, 8'hC2);
      hold_reset(1'b0);
   endtask

   initial begin
      t_reset();
      t_passthru();
      t_identify();
      t_hold();
      t_restart();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule